// File: doc/BRIEF.md
# Cipher Key Table with Address Lookup

This block stores per-station cipher keys for a wireless MAC and finds the key that belongs to a frame. Each table slot holds eight 32-bit words. Words 0 to 4 are key material, word 5 is the type word, and words 6 and 7 hold the peer address. Software reaches the slots through a simple 32-bit register bus. The bus address is `{slot index, word number}`. The words form four 64-bit locations, paired as (0,1), (2,3), (4,5) and (6,7). A location changes only when its odd word is written directly after its even word. A one-word shadow makes sure that a pair read back by software belongs together.

The receive and transmit paths present a 48-bit address on the lookup port. One cycle later the block returns whether an entry matched, the lowest matching slot index, its cipher code and its 128 bits of key material. A wipe command clears a slot. A small state machine runs the wipe through the states WS_IDLE, WS_MAIN and WS_MIC:
- WS_IDLE to WS_MAIN is taken on an accepted request.
- WS_MAIN to WS_MIC is taken when the slot being wiped is TKIP and its companion slot fits in the table.
- WS_MAIN to WS_IDLE is taken otherwise.
- WS_MIC always returns to WS_IDLE.

The MAC owns a power-management bit in each type word and sets it through a separate port.

Top module: `cipher_key_table`

## Requirements
- R1: An even-word write followed by an odd-word write to the same 64-bit location commits both words on the odd write. Bus word numbers 0..7 pair as (0,1), (2,3), (4,5) and (6,7).
- R2: An even word written alone changes nothing. An odd write that finds no pending even word for the same location is dropped. An even write to a different location replaces the pending one.
- R3: Key words 1 and 3 and address word 7 keep only their low 16 bits. They read back zero-extended.
- R4: Word 5 carries the cipher code in bits 2:0. The codes are 0 none, 1 WEP-40, 2 WEP-104, 3 WEP-128, 4 TKIP, 5 CCM and 6 OCB. Word 6 holds address bits 32:1. Word 7 holds address bits 47:33 in bits 14:0 and the unicast flag in bit 15.
- R5: Bit 8 of the type word changes only through the power-management port. A bus write to word 5 keeps the stored bit.
- R6: A slot index at or above TABLE_SIZE is rejected. Writes to it are dropped, reads of it return 0, wipes of it are ignored, and no other slot is touched.
- R7: A wipe zeroes all eight words of the slot. If the slot was TKIP (code 4) and index+64 lies inside the table, key words 0 to 4 of slot index+64 are zeroed one cycle later. Its type and address words are kept. Bus writes issued while a wipe runs are dropped.
- R8: A lookup request is answered one cycle later with lk_done. A slot matches when its code is not 0 and its stored bits 47:1 equal the request. A unicast slot additionally needs request bit 0 = 0, and a multicast slot needs request bit 0 = 1. A hit returns the cipher code and key {word4, word3[15:0], word2, word1[15:0], word0}.
- R9: When several slots match, the lowest index is reported. On a miss the index is all ones and the type and key are zero.
- R10: A slot at index N+64 is never matched while slot N holds a TKIP key.
- R11: Reading an even word captures its odd partner in a shadow. The next odd read of that location returns the captured value even if the location has been rewritten since.
- R12: After reset every word is zero, lk_done is low and bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | IDX_W+3 | {slot index, word number} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_re |
| wipe_req | input | 1 | Start wiping a slot |
| wipe_idx | input | IDX_W | Slot to wipe |
| pm_we | input | 1 | Power-management bit write |
| pm_idx | input | IDX_W | Slot for the power-management write |
| pm_val | input | 1 | New power-management bit value |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 48 | Frame address to search |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A slot matched |
| lk_idx | output | IDX_W | Matching slot, all ones on miss |
| lk_type | output | 3 | Cipher code of the match |
| lk_key | output | 128 | Key material of the match |

## Verification
A wrong pending-pair state shows up at the next read of the location. Such a read returns either a half-committed pair or a word that should have been dropped, one cycle after it is issued. Wrong slot contents or a wrong live mask show up on the very next lookup as a wrong hit, a wrong index or a wrong key. A wrong wipe sequence leaves nonzero words in the wiped slot or its companion; these are visible as soon as the wipe's three cycles have passed. A lost power-management bit appears on the following read of word 5.

// File: rtl/keytab_pkg.sv
package keytab_pkg;

    localparam int WORD_W  = 32;
    localparam int MAC_W   = 48;
    localparam int PM_BIT  = 8;
    localparam int UC_BIT  = 15;
    localparam int KEY_W   = 128;

    typedef enum logic [2:0] {
        CIPH_NONE   = 3'd0,
        CIPH_WEP40  = 3'd1,
        CIPH_WEP104 = 3'd2,
        CIPH_WEP128 = 3'd3,
        CIPH_TKIP   = 3'd4,
        CIPH_CCM    = 3'd5,
        CIPH_OCB    = 3'd6
    } cipher_e;

    typedef struct packed {
        logic [31:0] k0;
        logic [15:0] k1;
        logic [31:0] k2;
        logic [15:0] k3;
        logic [31:0] k4;
        logic [31:0] tw;
        logic [31:0] alo;
        logic [15:0] ahi;
    } slot_t;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_MAIN = 2'd1,
        WS_MIC  = 2'd2
    } wipe_st_e;

endpackage

// File: rtl/keytab_pairbuf.sv
module keytab_pairbuf #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             in_range,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_pair,
    input  logic             wr_odd,
    input  logic [31:0]      wr_data,
    input  logic             flush,
    output logic             commit,
    output logic [IDX_W-1:0] cm_idx,
    output logic [1:0]       cm_pair,
    output logic [31:0]      cm_lo,
    output logic [31:0]      cm_hi
);

    logic             pv;
    logic [IDX_W-1:0] pidx;
    logic [1:0]       ppair;
    logic [31:0]      pdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv    <= 1'b0;
            pidx  <= '0;
            ppair <= '0;
            pdata <= '0;
        end else if (flush) begin
            pv <= 1'b0;
        end else if (wr_en && in_range && !wr_odd) begin
            pv    <= 1'b1;
            pidx  <= wr_idx;
            ppair <= wr_pair;
            pdata <= wr_data;
        end else if (wr_en && wr_odd) begin
            pv <= 1'b0;
        end
    end

    always_comb begin
        commit  = wr_en && wr_odd && in_range && !flush && pv
                  && (pidx == wr_idx) && (ppair == wr_pair);
        cm_idx  = wr_idx;
        cm_pair = wr_pair;
        cm_lo   = pdata;
        cm_hi   = wr_data;
    end

    AST_PAIR_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pv); // R1

    AST_ODD_ENDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_odd) |=> !pv); // R2

endmodule

// File: rtl/keytab_wipe.sv
module keytab_wipe
    import keytab_pkg::*;
#(
    parameter int TABLE_SIZE = 128,
    parameter int IDX_W      = 8,
    parameter int MIC_OFS    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             tkip_here,
    output logic             busy,
    output logic             main_stb,
    output logic             mic_stb,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] mic_idx
);

    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(TABLE_SIZE);
    localparam logic [IDX_W:0] OFS   = (IDX_W+1)'(MIC_OFS);

    wipe_st_e st, nxt;
    logic     req_ok, mic_fits;

    assign req_ok   = ({1'b0, req_idx} < LIMIT);
    assign mic_fits = (({1'b0, cur_idx} + OFS) < LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= WS_IDLE;
            cur_idx <= '0;
        end else begin
            st <= nxt;
            if (st == WS_IDLE && req && req_ok)
                cur_idx <= req_idx;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            WS_IDLE: if (req && req_ok) nxt = WS_MAIN;
            WS_MAIN: nxt = (tkip_here && mic_fits) ? WS_MIC : WS_IDLE;
            WS_MIC:  nxt = WS_IDLE;
            default: nxt = WS_IDLE;
        endcase
    end

    always_comb begin
        busy     = (st != WS_IDLE);
        main_stb = (st == WS_MAIN);
        mic_stb  = (st == WS_MIC);
        mic_idx  = cur_idx + IDX_W'(MIC_OFS);
    end

    AST_MIC_FOLLOWS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_MIC) |-> ($past(st) == WS_MAIN)); // R7

    AST_WIPE_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, cur_idx} < LIMIT)); // R6

endmodule

// File: rtl/keytab_search.sv
module keytab_search #(
    parameter int TABLE_SIZE = 128,
    parameter int IDX_W      = 8
) (
    input  logic [TABLE_SIZE-1:0]       live,
    input  logic [TABLE_SIZE-1:0]       ucast,
    input  logic [TABLE_SIZE-1:0][46:0] tag,
    input  logic [47:0]                 addr,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);

    logic [TABLE_SIZE-1:0] match;

    for (genvar g = 0; g < TABLE_SIZE; g++) begin : g_cmp
        assign match[g] = live[g] && (tag[g] == addr[47:1])
                          && (ucast[g] ? !addr[0] : addr[0]);
    end

    always_comb begin
        hit = 1'b0;
        idx = '1;
        for (int i = TABLE_SIZE - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cipher_key_table.sv
module cipher_key_table
    import keytab_pkg::*;
#(
    parameter int TABLE_SIZE = 128,
    parameter int IDX_W      = 8,
    parameter int MIC_OFS    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [IDX_W+2:0]   bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               wipe_req,
    input  logic [IDX_W-1:0]   wipe_idx,
    input  logic               pm_we,
    input  logic [IDX_W-1:0]   pm_idx,
    input  logic               pm_val,
    input  logic               lk_req,
    input  logic [47:0]        lk_addr,
    output logic               lk_done,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [2:0]         lk_type,
    output logic [127:0]       lk_key
);

    localparam int             SLOT_W = $clog2(TABLE_SIZE);
    localparam logic [IDX_W:0] LIMIT  = (IDX_W+1)'(TABLE_SIZE);

    slot_t tbl [TABLE_SIZE];

    logic [IDX_W-1:0] a_idx;
    logic [2:0]       a_word;
    logic             a_ok, pm_ok;
    assign a_idx  = bus_addr[IDX_W+2:3];
    assign a_word = bus_addr[2:0];
    assign a_ok   = ({1'b0, a_idx} < LIMIT);
    assign pm_ok  = ({1'b0, pm_idx} < LIMIT);

    logic             w_busy, w_main, w_mic, w_tkip;
    logic [IDX_W-1:0] w_cur, w_mic_idx;

    keytab_wipe #(.TABLE_SIZE(TABLE_SIZE), .IDX_W(IDX_W), .MIC_OFS(MIC_OFS)) u_wipe (
        .clk(clk), .rst_n(rst_n), .req(wipe_req), .req_idx(wipe_idx),
        .tkip_here(w_tkip), .busy(w_busy), .main_stb(w_main), .mic_stb(w_mic),
        .cur_idx(w_cur), .mic_idx(w_mic_idx)
    );

    assign w_tkip = (tbl[w_cur[SLOT_W-1:0]].tw[2:0] == CIPH_TKIP);

    logic             cm_v;
    logic [IDX_W-1:0] cm_idx;
    logic [1:0]       cm_pair;
    logic [31:0]      cm_lo, cm_hi;

    keytab_pairbuf #(.IDX_W(IDX_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we && !w_busy), .in_range(a_ok),
        .wr_idx(a_idx), .wr_pair(a_word[2:1]), .wr_odd(a_word[0]),
        .wr_data(bus_wdata), .flush(w_busy), .commit(cm_v), .cm_idx(cm_idx),
        .cm_pair(cm_pair), .cm_lo(cm_lo), .cm_hi(cm_hi)
    );

    // storage update: wipe first, then bus commit, power-management bit last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TABLE_SIZE; i++) tbl[i] <= '0;
        end else begin
            if (w_main) begin
                tbl[w_cur[SLOT_W-1:0]] <= '0;
            end else if (w_mic) begin
                tbl[w_mic_idx[SLOT_W-1:0]].k0 <= '0;
                tbl[w_mic_idx[SLOT_W-1:0]].k1 <= '0;
                tbl[w_mic_idx[SLOT_W-1:0]].k2 <= '0;
                tbl[w_mic_idx[SLOT_W-1:0]].k3 <= '0;
                tbl[w_mic_idx[SLOT_W-1:0]].k4 <= '0;
            end else if (cm_v) begin
                unique case (cm_pair)
                    2'd0: begin
                        tbl[cm_idx[SLOT_W-1:0]].k0 <= cm_lo;
                        tbl[cm_idx[SLOT_W-1:0]].k1 <= cm_hi[15:0];
                    end
                    2'd1: begin
                        tbl[cm_idx[SLOT_W-1:0]].k2 <= cm_lo;
                        tbl[cm_idx[SLOT_W-1:0]].k3 <= cm_hi[15:0];
                    end
                    2'd2: begin
                        tbl[cm_idx[SLOT_W-1:0]].k4 <= cm_lo;
                        tbl[cm_idx[SLOT_W-1:0]].tw <= {cm_hi[31:PM_BIT+1],
                            tbl[cm_idx[SLOT_W-1:0]].tw[PM_BIT], cm_hi[PM_BIT-1:0]};
                    end
                    default: begin
                        tbl[cm_idx[SLOT_W-1:0]].alo <= cm_lo;
                        tbl[cm_idx[SLOT_W-1:0]].ahi <= cm_hi[15:0];
                    end
                endcase
            end
            if (pm_we && pm_ok)
                tbl[pm_idx[SLOT_W-1:0]].tw[PM_BIT] <= pm_val;
        end
    end

    function automatic logic [31:0] pick(slot_t s, logic [2:0] w);
        logic [31:0] r;
        unique case (w)
            3'd0: r = s.k0;
            3'd1: r = {16'h0, s.k1};
            3'd2: r = s.k2;
            3'd3: r = {16'h0, s.k3};
            3'd4: r = s.k4;
            3'd5: r = s.tw;
            3'd6: r = s.alo;
            default: r = {16'h0, s.ahi};
        endcase
        return r;
    endfunction

    logic [31:0]      shadow;
    logic             sh_v;
    logic [IDX_W+1:0] sh_tag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            shadow    <= '0;
            sh_v      <= 1'b0;
            sh_tag    <= '0;
        end else if (bus_re) begin
            if (!a_ok) begin
                bus_rdata <= '0;
            end else if (!a_word[0]) begin
                bus_rdata <= pick(tbl[a_idx[SLOT_W-1:0]], a_word);
                shadow    <= pick(tbl[a_idx[SLOT_W-1:0]], {a_word[2:1], 1'b1});
                sh_v      <= 1'b1;
                sh_tag    <= {a_idx, a_word[2:1]};
            end else if (sh_v && sh_tag == {a_idx, a_word[2:1]}) begin
                bus_rdata <= shadow;
            end else begin
                bus_rdata <= pick(tbl[a_idx[SLOT_W-1:0]], a_word);
            end
        end
    end

    logic [TABLE_SIZE-1:0]       s_live, s_uc, s_tkip;
    logic [TABLE_SIZE-1:0][46:0] s_tag;
    logic [TABLE_SIZE-1:0]       pm_vec;

    for (genvar g = 0; g < TABLE_SIZE; g++) begin : g_slot
        assign s_tkip[g] = (tbl[g].tw[2:0] == CIPH_TKIP);
        assign s_tag[g]  = {tbl[g].ahi[14:0], tbl[g].alo};
        assign s_uc[g]   = tbl[g].ahi[UC_BIT];
        assign pm_vec[g] = tbl[g].tw[PM_BIT];
        if (g >= MIC_OFS) begin : g_comp
            assign s_live[g] = (tbl[g].tw[2:0] != CIPH_NONE) && !s_tkip[g-MIC_OFS];
        end else begin : g_plain
            assign s_live[g] = (tbl[g].tw[2:0] != CIPH_NONE);
        end
    end

    logic             f_hit;
    logic [IDX_W-1:0] f_idx;

    keytab_search #(.TABLE_SIZE(TABLE_SIZE), .IDX_W(IDX_W)) u_search (
        .live(s_live), .ucast(s_uc), .tag(s_tag), .addr(lk_addr),
        .hit(f_hit), .idx(f_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done <= 1'b0;
            lk_hit  <= 1'b0;
            lk_idx  <= '1;
            lk_type <= '0;
            lk_key  <= '0;
        end else begin
            lk_done <= lk_req;
            if (lk_req) begin
                lk_hit <= f_hit;
                lk_idx <= f_idx;
                if (f_hit) begin
                    lk_type <= tbl[f_idx[SLOT_W-1:0]].tw[2:0];
                    lk_key  <= {tbl[f_idx[SLOT_W-1:0]].k4, tbl[f_idx[SLOT_W-1:0]].k3,
                                tbl[f_idx[SLOT_W-1:0]].k2, tbl[f_idx[SLOT_W-1:0]].k1,
                                tbl[f_idx[SLOT_W-1:0]].k0};
                end else begin
                    lk_type <= '0;
                    lk_key  <= '0;
                end
            end
        end
    end

    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_done); // R8

    AST_HIT_NOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_hit) |-> (lk_type != CIPH_NONE)); // R8

    AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit) |-> (lk_idx == '1 && lk_type == '0)); // R9

    AST_HIT_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_hit) |-> ({1'b0, lk_idx} < LIMIT)); // R6

    AST_PM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm_we && !w_main) |=> $stable(pm_vec)); // R5

endmodule

// File: tb/cipher_key_table_test.sv
module cipher_key_table_test;

    localparam int IDX_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_we = 1'b0, bus_re = 1'b0;
    logic [IDX_W+2:0]   bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               wipe_req = 1'b0;
    logic [IDX_W-1:0]   wipe_idx = '0;
    logic               pm_we = 1'b0;
    logic [IDX_W-1:0]   pm_idx = '0;
    logic               pm_val = 1'b0;
    logic               lk_req = 1'b0;
    logic [47:0]        lk_addr = '0;
    logic               lk_done, lk_hit;
    logic [IDX_W-1:0]   lk_idx;
    logic [2:0]         lk_type;
    logic [127:0]       lk_key;

    int vec = 0;
    int bad = 0;

    cipher_key_table uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wipe_req(wipe_req), .wipe_idx(wipe_idx), .pm_we(pm_we), .pm_idx(pm_idx),
        .pm_val(pm_val), .lk_req(lk_req), .lk_addr(lk_addr), .lk_done(lk_done),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_type(lk_type), .lk_key(lk_key)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        bad++;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input int idx, input int w, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = {idx[7:0], w[2:0]}; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic br(input int idx, input int w, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = {idx[7:0], w[2:0]};
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic look(input logic [47:0] a);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic wipe(input int idx);
        @(negedge clk);
        wipe_req = 1'b1; wipe_idx = idx[7:0];
        @(negedge clk);
        wipe_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [127:0] exp_key(input int idx);
        return {32'h4000_0000 + idx, 16'h3300 + idx[15:0], 32'h2000_0000 + idx,
                16'h1100 + idx[15:0], 32'h1000_0000 + idx};
    endfunction

    task automatic prog(input int idx, input logic [31:0] tw, input logic [47:0] a, input logic uc);
        bw(idx, 0, 32'h1000_0000 + idx);
        bw(idx, 1, 32'hFFFF_1100 + idx);
        bw(idx, 2, 32'h2000_0000 + idx);
        bw(idx, 3, 32'hEEEE_3300 + idx);
        bw(idx, 4, 32'h4000_0000 + idx);
        bw(idx, 5, tw);
        bw(idx, 6, a[32:1]);
        bw(idx, 7, {16'h0, uc, a[47:33]});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R12 rdata after reset", bus_rdata, 0);
        chk("R12 lk_done after reset", lk_done, 0);
        br(5, 0, d);  chk("R12 slot word zero", d, 0);
        br(127, 5, d); chk("R12 type word zero", d, 0);
    endtask

    task automatic t_pairing;
        logic [31:0] d;
        bw(10, 0, 32'hCAFE_0001);
        br(10, 0, d); chk("R2 even alone no change", d, 0);
        bw(10, 1, 32'h5555_ABCD);
        br(10, 0, d); chk("R1 even word committed", d, 32'hCAFE_0001);
        br(10, 1, d); chk("R3 odd word low 16 bits", d, 32'h0000_ABCD);
        bw(11, 3, 32'h0000_7777);
        br(11, 3, d); chk("R2 orphan odd dropped", d, 0);
        bw(11, 2, 32'h1234_5678);
        bw(12, 0, 32'h9999_9999);
        bw(11, 3, 32'h0000_4444);
        br(11, 2, d); chk("R2 replaced pending drops odd", d, 0);
    endtask

    task automatic t_pm;
        logic [31:0] d;
        @(negedge clk); pm_we = 1'b1; pm_idx = 8'd14; pm_val = 1'b1;
        @(negedge clk); pm_we = 1'b0;
        bw(14, 4, 32'h0);
        bw(14, 5, 32'h0000_0004);
        br(14, 5, d); chk("R5 pm bit kept at 1", d, 32'h0000_0104);
        bw(15, 4, 32'h0);
        bw(15, 5, 32'h0000_0105);
        br(15, 5, d); chk("R5 pm bit kept at 0", d, 32'h0000_0005);
    endtask

    task automatic t_range;
        logic [31:0] d;
        bw(200, 0, 32'hDEAD_BEEF);
        bw(200, 1, 32'hDEAD_BEEF);
        br(72, 0, d);  chk("R6 no alias write", d, 0);
        br(200, 0, d); chk("R6 out of range read zero", d, 0);
        prog(22, 32'h5, 48'h0A0B_0C0D_0E10, 1'b1);
        wipe(150);
        br(22, 0, d);  chk("R6 out of range wipe ignored", d, 32'h1000_0016);
    endtask

    task automatic t_lookup;
        logic [47:0] a  = 48'h0012_3456_789A;
        logic [47:0] m  = 48'h0133_5577_99BB;
        logic [47:0] p  = 48'h00AA_BBCC_DDEE;
        logic [31:0] d;
        prog(20, 32'h5, a, 1'b1);
        br(20, 6, d); chk("R4 address low word", d, a[32:1]);
        br(20, 7, d); chk("R4 address high word with unicast", d, {16'h0, 1'b1, a[47:33]});
        look(a);
        chk("R8 unicast hit", {lk_done, lk_hit, lk_idx, lk_type}, {1'b1, 1'b1, 8'd20, 3'd5});
        chk("R8 key material", lk_key, exp_key(20));
        look(a | 48'h1);
        chk("R9 miss reports all ones", {lk_hit, lk_idx, lk_type, lk_key}, {1'b0, 8'hFF, 3'd0, 128'h0});
        prog(30, 32'h1, m, 1'b0);
        look(m);
        chk("R8 multicast hit", {lk_hit, lk_idx, lk_type}, {1'b1, 8'd30, 3'd1});
        look(m & ~48'h1);
        chk("R8 multicast needs group bit", lk_hit, 0);
        prog(40, 32'h1, p, 1'b1);
        prog(35, 32'h2, p, 1'b1);
        prog(33, 32'h0, p, 1'b1);
        look(p);
        chk("R9 lowest index wins", {lk_hit, lk_idx, lk_type}, {1'b1, 8'd35, 3'd2});
    endtask

    task automatic t_tkip;
        logic [47:0] t = 48'h0020_3040_5060;
        logic [47:0] u = 48'h0070_8090_A0B0;
        logic [31:0] d;
        prog(84, 32'h0, 48'h0, 1'b1);
        prog(3, 32'h4, t, 1'b1);
        prog(67, 32'h5, u, 1'b1);
        look(u);
        chk("R10 companion not matched", lk_hit, 0);
        look(t);
        chk("R8 tkip slot hit", {lk_hit, lk_idx, lk_type}, {1'b1, 8'd3, 3'd4});
        wipe(3);
        br(3, 0, d); chk("R7 wiped key word", d, 0);
        br(3, 5, d); chk("R7 wiped type word", d, 0);
        br(3, 6, d); chk("R7 wiped address low", d, 0);
        br(3, 7, d); chk("R7 wiped address high", d, 0);
        br(67, 0, d); chk("R7 companion key cleared", d, 0);
        br(67, 4, d); chk("R7 companion key word 4 cleared", d, 0);
        br(67, 5, d); chk("R7 companion type kept", d, 32'h5);
        look(u);
        chk("R10 companion live after wipe", {lk_hit, lk_idx}, {1'b1, 8'd67});
        wipe(20);
        br(84, 0, d); chk("R7 non-tkip wipe leaves +64 slot", d, 32'h1000_0054);
        @(negedge clk);
        wipe_req = 1'b1; wipe_idx = 8'd60;
        @(negedge clk);
        wipe_req = 1'b0;
        bus_we = 1'b1; bus_addr = {8'd61, 3'd0}; bus_wdata = 32'h7777_0000;
        @(negedge clk);
        bus_addr = {8'd61, 3'd1}; bus_wdata = 32'h0000_1111;
        @(negedge clk);
        bus_we = 1'b0;
        br(61, 0, d); chk("R7 write during wipe dropped", d, 0);
    endtask

    task automatic t_shadow;
        logic [31:0] d;
        bw(50, 0, 32'hAAAA_0001);
        bw(50, 1, 32'h0000_B001);
        br(50, 0, d); chk("R11 even read", d, 32'hAAAA_0001);
        bw(50, 0, 32'hCCCC_0002);
        bw(50, 1, 32'h0000_D002);
        br(50, 1, d); chk("R11 shadow returns captured odd", d, 32'h0000_B001);
        br(50, 0, d); chk("R11 fresh even read", d, 32'hCCCC_0002);
        br(50, 1, d); chk("R11 fresh odd read", d, 32'h0000_D002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_pairing;
        t_pm;
        t_range;
        t_lookup;
        t_tkip;
        t_shadow;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule